// File: doc/BRIEF.md
# Grouped Interrupt Combiner

The block gathers a wide field of level-sensitive interrupt sources into groups of eight and drives one output line per group. A group line is high when at least one of its sources is both asserted and enabled. Source index `n` belongs to group `n>>3` at bit position `n&7`. The pending state of a source is not latched. It simply tracks the input level as sampled on each clock.

Software controls the enables through a 32-bit register window with a single-cycle write strobe and a combinational read path. Each 16-byte quad of the window serves four consecutive groups, one byte lane per group. The quad offers a set-enable register, a clear-enable register, a raw-status view and a masked-status view. Two summary words follow the last quad and carry one bit per group for the masked result.

A parameter limits the number of live groups for a smaller instance. Sources in the groups above that limit are ignored. Writes that would target a read-only or unmapped location change nothing and raise a one-cycle error pulse.

Top module: `irq_combiner`

## Requirements
- R1: `grp_o[g]` is a register that equals the OR of (enable byte AND pending byte) of group g. It updates on the clock edge at which the input level or the enable write takes effect.
- R2: A pending bit equals the level of its input as sampled at the last clock edge. It drops as soon as the input is sampled low.
- R3: A write with `addr_i[3:2]`=0 to quad q = `addr_i[8:4]` (q < 16) ORs byte lane k (`wdata_i[8k+7:8k]`) into the enable byte of group 4q+k. Zero bits leave enables unchanged.
- R4: A write with `addr_i[3:2]`=1 to quad q clears each enable bit of group 4q+k for which lane k holds a one.
- R5: A read with `addr_i[3:2]`=2 returns the raw pending bytes of groups 4q..4q+3 in lanes 0..3. A read with `addr_i[3:2]`=3 returns the same bytes ANDed with the enables.
- R6: A read at 0x100 returns one masked-active bit per group for groups 0–31. A read at 0x104 does the same for groups 32–63. Each bit always matches `grp_o`.
- R7: While `rst_ni` is low, all enables, all pending bits and all group outputs are zero.
- R8: A write to a status register, to the summary words, to a misaligned address or beyond 0x107 leaves all enables unchanged. It sets `err_o` for exactly the following cycle.
- R9: Groups at or above `ACTIVE_GROUPS` keep their output and their raw status at zero whatever their inputs are.
- R10: Reads of the two enable registers, of misaligned addresses and of addresses beyond the summary words return zero.
- R11: Input index n drives pending bit n&7 of group n>>3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_i | input | NUM_GROUPS*8 | Level interrupt sources |
| wr_en_i | input | 1 | Single-cycle write strobe |
| addr_i | input | ADDR_W | Byte address in the register window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational from state |
| err_o | output | 1 | One-cycle pulse after an illegal write |
| grp_o | output | NUM_GROUPS | Registered per-group interrupt lines |

## Verification
The assertions assume two things. First, `wr_en_i` is a single-cycle strobe whose address and data are stable around the sampling edge. Second, the sources are synchronous to `clk_i`, so an input level and the enables are sampled together. The stimulus meets both assumptions by changing inputs, address and strobe only on the falling edge and by holding each write for exactly one rising edge. The random writes mix legal set and clear writes with deliberately illegal addresses. This lets the checks that illegal writes leave the enables unchanged trigger often, and no assumption on the protocol is broken.

// File: rtl/irq_comb_pkg.sv
package irq_comb_pkg;
  localparam int SRC_PER_GRP  = 8;
  localparam int GRP_PER_QUAD = 4;

  typedef enum logic [1:0] {
    REG_EN_SET = 2'd0,
    REG_EN_CLR = 2'd1,
    REG_RAW    = 2'd2,
    REG_MASKED = 2'd3
  } quad_reg_e;
endpackage

// File: rtl/irq_comb_src_bank.sv
module irq_comb_src_bank import irq_comb_pkg::*; #(
  parameter int NUM_GROUPS    = 64,
  parameter int ACTIVE_GROUPS = 64,
  localparam int NUM_SRC      = NUM_GROUPS * SRC_PER_GRP
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] irq_i,
  output logic [NUM_SRC-1:0] pend_d_o,
  output logic [NUM_SRC-1:0] pend_q_o
);
  logic [NUM_SRC-1:0] pend_q;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    if (g < ACTIVE_GROUPS) begin : g_live
      assign pend_d_o[g*SRC_PER_GRP +: SRC_PER_GRP] = irq_i[g*SRC_PER_GRP +: SRC_PER_GRP];
    end else begin : g_dead
      assign pend_d_o[g*SRC_PER_GRP +: SRC_PER_GRP] = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d_o;
  end

  assign pend_q_o = pend_q;
endmodule

// File: rtl/irq_comb_mask_regs.sv
module irq_comb_mask_regs import irq_comb_pkg::*; #(
  parameter int NUM_GROUPS = 64,
  parameter int ADDR_W     = 9,
  localparam int NUM_BITS  = NUM_GROUPS * SRC_PER_GRP,
  localparam int NUM_QUADS = NUM_GROUPS / GRP_PER_QUAD,
  localparam int QW        = ADDR_W - 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [31:0]         wdata_i,
  output logic [NUM_BITS-1:0] mask_d_o,
  output logic [NUM_BITS-1:0] mask_q_o,
  output logic                err_o
);
  logic [NUM_BITS-1:0] mask_q, set_vec, clr_vec;
  logic [QW-1:0]       quad;
  quad_reg_e           reg_sel;
  logic                in_quads, aligned, set_wr, clr_wr, bad_wr, err_q;

  assign quad     = addr_i[ADDR_W-1:4];
  assign reg_sel  = quad_reg_e'(addr_i[3:2]);
  assign aligned  = (addr_i[1:0] == 2'b00);
  assign in_quads = (int'(quad) < NUM_QUADS);
  assign set_wr   = wr_en_i && aligned && in_quads && (reg_sel == REG_EN_SET);
  assign clr_wr   = wr_en_i && aligned && in_quads && (reg_sel == REG_EN_CLR);
  assign bad_wr   = wr_en_i && !set_wr && !clr_wr;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam int QI = g / GRP_PER_QUAD;
    localparam int LN = g % GRP_PER_QUAD;
    logic hit;
    assign hit = (int'(quad) == QI);
    assign set_vec[g*8 +: 8] = (set_wr && hit) ? wdata_i[LN*8 +: 8] : 8'h00;
    assign clr_vec[g*8 +: 8] = (clr_wr && hit) ? wdata_i[LN*8 +: 8] : 8'h00;
  end

  assign mask_d_o = (mask_q | set_vec) & ~clr_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      err_q  <= 1'b0;
    end else begin
      mask_q <= mask_d_o;
      err_q  <= bad_wr;
    end
  end

  assign mask_q_o = mask_q;
  assign err_o    = err_q;

  // R8
  illegal_wr_no_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_wr |=> (mask_q == $past(mask_q)));
  // R8
  err_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(wr_en_i));
  // R3
  set_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_wr |=> ((mask_q & $past(set_vec)) == $past(set_vec)));
  // R4
  clr_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr |=> ((mask_q & $past(clr_vec)) == '0));
endmodule

// File: rtl/irq_comb_read_mux.sv
module irq_comb_read_mux import irq_comb_pkg::*; #(
  parameter int NUM_GROUPS = 64,
  parameter int ADDR_W     = 9,
  localparam int NUM_BITS  = NUM_GROUPS * SRC_PER_GRP,
  localparam int NUM_QUADS = NUM_GROUPS / GRP_PER_QUAD,
  localparam int SUM_WORDS = (NUM_GROUPS + 31) / 32,
  localparam int QW        = ADDR_W - 4,
  localparam int WW        = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [NUM_BITS-1:0]   mask_i,
  input  logic [NUM_BITS-1:0]   pend_i,
  output logic [31:0]           rdata_o,
  output logic [NUM_GROUPS-1:0] sum_o
);
  logic [NUM_BITS-1:0]     masked;
  logic [SUM_WORDS*32-1:0] sum_pad;
  logic [QW-1:0]           quad;
  logic [WW-1:0]           word;
  quad_reg_e               reg_sel;

  assign masked  = mask_i & pend_i;
  assign quad    = addr_i[ADDR_W-1:4];
  assign word    = addr_i[ADDR_W-1:2];
  assign reg_sel = quad_reg_e'(addr_i[3:2]);

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_sum
    assign sum_o[g] = |masked[g*8 +: 8];
  end

  always_comb begin
    sum_pad = '0;
    sum_pad[NUM_GROUPS-1:0] = sum_o;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i[1:0] == 2'b00) begin
      if (int'(quad) < NUM_QUADS) begin
        for (int k = 0; k < GRP_PER_QUAD; k++) begin
          if (reg_sel == REG_RAW)
            rdata_o[k*8 +: 8] = pend_i[(int'(quad)*GRP_PER_QUAD + k)*8 +: 8];
          else if (reg_sel == REG_MASKED)
            rdata_o[k*8 +: 8] = masked[(int'(quad)*GRP_PER_QUAD + k)*8 +: 8];
        end
      end else begin
        for (int w = 0; w < SUM_WORDS; w++)
          if (int'(word) == NUM_GROUPS + w) rdata_o = sum_pad[w*32 +: 32];
      end
    end
  end
endmodule

// File: rtl/irq_combiner.sv
module irq_combiner import irq_comb_pkg::*; #(
  parameter int NUM_GROUPS    = 64,
  parameter int ACTIVE_GROUPS = 64,
  localparam int NUM_SRC      = NUM_GROUPS * SRC_PER_GRP,
  localparam int SUM_WORDS    = (NUM_GROUPS + 31) / 32,
  localparam int ADDR_W       = $clog2(NUM_GROUPS * 4 + SUM_WORDS * 4)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_SRC-1:0]    irq_i,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [31:0]           wdata_i,
  output logic [31:0]           rdata_o,
  output logic                  err_o,
  output logic [NUM_GROUPS-1:0] grp_o
);
  logic [NUM_SRC-1:0]    pend_d, pend_q, mask_d, mask_q;
  logic [NUM_GROUPS-1:0] grp_d, grp_q, sum_vec;

  irq_comb_src_bank #(.NUM_GROUPS(NUM_GROUPS), .ACTIVE_GROUPS(ACTIVE_GROUPS)) u_src (
    .clk_i, .rst_ni, .irq_i, .pend_d_o(pend_d), .pend_q_o(pend_q)
  );

  irq_comb_mask_regs #(.NUM_GROUPS(NUM_GROUPS), .ADDR_W(ADDR_W)) u_mask (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .mask_d_o(mask_d), .mask_q_o(mask_q), .err_o
  );

  irq_comb_read_mux #(.NUM_GROUPS(NUM_GROUPS), .ADDR_W(ADDR_W)) u_rd (
    .addr_i, .mask_i(mask_q), .pend_i(pend_q), .rdata_o, .sum_o(sum_vec)
  );

  // next-state OR keeps the output flop aligned with mask and pending flops
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_out
    assign grp_d[g] = |(mask_d[g*8 +: 8] & pend_d[g*8 +: 8]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) grp_q <= '0;
    else         grp_q <= grp_d;
  end

  assign grp_o = grp_q;

  // R1
  idle_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |-> (grp_o == '0));
  // R6
  sum_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sum_vec == grp_o);
endmodule

// File: tb/irq_combiner_tb.sv
module irq_combiner_tb;
  localparam int NG  = 64;
  localparam int ACT = 60;
  localparam int NS  = NG * 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] irq = '0;
  logic          wr_en = 1'b0;
  logic [8:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          err;
  logic [NG-1:0] grp;

  logic [7:0] m_mask [NG];
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_combiner #(.NUM_GROUPS(NG), .ACTIVE_GROUPS(ACT)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .err_o(err), .grp_o(grp)
  );

  function automatic logic [7:0] m_pend(int g);
    return (g < ACT) ? irq[g*8 +: 8] : 8'h00;
  endfunction

  function automatic logic [NG-1:0] m_grp();
    logic [NG-1:0] v = '0;
    for (int g = 0; g < NG; g++) v[g] = |(m_pend(g) & m_mask[g]);
    return v;
  endfunction

  function automatic bit m_legal(logic [8:0] a);
    return (a[1:0] == 2'b00) && (a < 9'h100) && (a[3:2] < 2'd2);
  endfunction

  function automatic logic [31:0] m_read(logic [8:0] a);
    logic [31:0]   v = '0;
    logic [NG-1:0] s = m_grp();
    int q = int'(a[8:4]);
    if (a[1:0] != 2'b00) return '0;
    if (a < 9'h100) begin
      for (int k = 0; k < 4; k++) begin
        if (a[3:2] == 2'd2) v[k*8 +: 8] = m_pend(q*4 + k);
        else if (a[3:2] == 2'd3) v[k*8 +: 8] = m_pend(q*4 + k) & m_mask[q*4 + k];
      end
    end else if (a == 9'h100) v = s[31:0];
    else if (a == 9'h104) v = s[63:32];
    return v;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [8:0] a, logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    step();
    wr_en = 1'b0;
    if (m_legal(a)) begin
      for (int k = 0; k < 4; k++) begin
        if (a[3:2] == 2'd0) m_mask[int'(a[8:4])*4 + k] |= d[k*8 +: 8];
        else                m_mask[int'(a[8:4])*4 + k] &= ~d[k*8 +: 8];
      end
    end
  endtask

  task automatic rd_chk(string req, logic [8:0] a);
    addr = a;
    #1;
    check(req, {32'h0, rdata}, {32'h0, m_read(a)});
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5));
    for (int g = 0; g < NG; g++) m_mask[g] = 8'h00;
    // R7: reset holds pending and outputs at zero even with inputs high
    irq = '1;
    repeat (3) @(negedge clk);
    addr = 9'h008; #1;
    check("R7 raw status in reset", {32'h0, rdata}, 64'h0);
    check("R7 grp in reset", grp, '0);
    rst_n = 1'b1;
    irq = '0;
    step();
    check("R7 grp after reset", grp, '0);

    // R11: source 13*8+5 lands in group 13 bit 5 (quad 3 lane 1)
    irq[13*8 + 5] = 1'b1;
    step();
    rd_chk("R11 raw lane", 9'h038);
    check("R11 raw value", {32'h0, rdata}, 64'h2000);
    check("R1 masked off", grp, '0);
    // R3: enable set raises the group output on the write edge
    wr(9'h030, 32'h0000_2000);
    check("R3 grp after set", grp, m_grp());
    check("R3 grp13 high", {63'h0, grp[13]}, 64'h1);
    rd_chk("R5 masked", 9'h03C);
    rd_chk("R6 summary lo", 9'h100);
    // R10: enable registers read zero
    rd_chk("R10 set reg read", 9'h030);
    rd_chk("R10 clr reg read", 9'h034);
    // R3: zero write changes nothing
    wr(9'h030, 32'h0);
    check("R3 zero write", grp, m_grp());
    rd_chk("R3 masked kept", 9'h03C);
    // R2: input low drops pending and output
    irq[13*8 + 5] = 1'b0;
    step();
    check("R2 grp after drop", grp, '0);
    rd_chk("R2 raw after drop", 9'h038);
    irq[13*8 + 5] = 1'b1;
    step();
    check("R2 grp after rise", grp, m_grp());
    // R8: illegal writes
    wr(9'h038, 32'hFFFF_FFFF);
    check("R8 err pulse", {63'h0, err}, 64'h1);
    rd_chk("R8 masked unchanged", 9'h03C);
    step();
    check("R8 err one cycle", {63'h0, err}, 64'h0);
    wr(9'h100, 32'hFFFF_FFFF);
    check("R8 err summary wr", {63'h0, err}, 64'h1);
    wr(9'h034 | 9'h1, 32'hFFFF_FFFF);
    check("R8 err misaligned", {63'h0, err}, 64'h1);
    check("R8 grp unchanged", grp, m_grp());
    // R4: clear enable
    wr(9'h034, 32'h0000_2000);
    check("R4 grp after clr", grp, '0);
    check("R4 no err on legal", {63'h0, err}, 64'h0);
    // R9: group 61 ignored
    irq[61*8 +: 8] = 8'hFF;
    wr(9'h0F0, 32'hFFFF_FFFF);
    check("R9 grp61 low", {63'h0, grp[61]}, 64'h0);
    rd_chk("R9 raw zero", 9'h0F8);
    rd_chk("R6 summary hi", 9'h104);
    rd_chk("R10 beyond window", 9'h108);

    // random mix
    for (int it = 0; it < 400; it++) begin
      for (int w = 0; w < NS / 32; w++)
        irq[w*32 +: 32] = $urandom() & $urandom();
      if ($urandom_range(0, 9) == 0)
        wr(9'($urandom_range(0, 511)), $urandom());
      else
        wr({4'($urandom_range(0, 15)), 1'b0, 1'b0, 1'($urandom_range(0, 1)), 2'b00}, $urandom());
      check("R1 random grp", grp, m_grp());
      rd_chk("R5 random raw", {4'($urandom_range(0, 15)), 5'b01000});
      rd_chk("R5 random masked", {4'($urandom_range(0, 15)), 5'b01100});
      rd_chk("R6 random sum lo", 9'h100);
      rd_chk("R6 random sum hi", 9'h104);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule